// File: doc/BRIEF.md
# Masked BSSID Receive Acceptance Filter

This block decides, one received frame at a time, whether the frame's 48-bit BSSID belongs to the station and should therefore be accepted and acknowledged. It holds the station's own MAC address and a BSSID mask. A frame passes when the BSSID bits chosen by the mask agree with the same bits of the own MAC. Bits outside the mask are ignored, so a device that serves several BSSIDs can cover all of them with one compare. The price is that unrelated BSSIDs which happen to agree on the masked bits also pass.

Software writes the MAC and the mask as two words each: a low word for address bits 31:0 and an upper word for bits 47:32. Address byte 0 sits in bits 7:0 of the low word. Software can also let the hardware build the mask. It first starts the accumulator at all ones and then feeds in each served BSSID. Each feed clears the mask bits on which that BSSID differs from the own MAC. A load command then copies the result into the live mask.

Received BSSIDs arrive on a valid/ready stream, and verdicts leave on a valid/ready stream with one register between them. The input is ready whenever the output register is empty or is being drained in the same cycle. A verdict that the consumer stalls stays on the output unchanged, and the input is held off until the verdict is taken. With the consumer always ready, the block takes one BSSID per clock.

Top module: `bssid_filter`

## Requirements
- R1: Reset sets the mask to all ones, the own MAC to zero, the accumulator to all ones and clears `res_valid`. `bid_ready` is 1 while the block is idle.
- R2: A handshaken BSSID (`bid_valid && bid_ready`) gives a verdict `res_accept` = 1 exactly when (BSSID AND mask) equals (own MAC AND mask). The mask and MAC used are the register values in the handshake cycle.
- R3: `mac_lo_we`/`mask_lo_we` load `cfg_wdata[31:0]` into bits 31:0. `mac_hi_we`/`mask_hi_we` load `cfg_wdata[15:0]` into bits 47:32. The other half of the register is left unchanged.
- R4: `acc_init` sets the accumulator to all ones. `acc_add` ANDs the accumulator with NOT(own MAC XOR `acc_bssid`). `acc_init` wins when both are asserted. `acc_mask` shows the accumulator.
- R5: `acc_load` copies the accumulator into the mask. It takes priority over mask word writes in the same cycle.
- R6: A verdict appears on `res_valid`/`res_accept` in the cycle after the handshake. With `res_ready` held at 1, a new BSSID is taken every cycle.
- R7: `bid_ready` = NOT `res_valid` OR `res_ready`. While `res_valid && !res_ready`, `res_valid` and `res_accept` hold, and a presented BSSID is not taken.
- R8: With an all-ones mask, only a BSSID equal to the own MAC is accepted.
- R9: Take MAC = 1 and the served BSSIDs 4 and 9, with all upper bits zero. The accumulated mask is 0xFFFF_FFFF_FFF2. Under it, 6 is rejected, while 1, 4, 9 and 13 are accepted (13 is a false accept).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wdata | input | 32 | Write data for the word write strobes |
| mac_lo_we | input | 1 | Write MAC bits 31:0 |
| mac_hi_we | input | 1 | Write MAC bits 47:32 |
| mask_lo_we | input | 1 | Write mask bits 31:0 |
| mask_hi_we | input | 1 | Write mask bits 47:32 |
| acc_init | input | 1 | Set the accumulator to all ones |
| acc_add | input | 1 | Fold `acc_bssid` into the accumulator |
| acc_bssid | input | 48 | Served BSSID to fold in |
| acc_load | input | 1 | Copy the accumulator into the mask |
| acc_mask | output | 48 | Accumulator readback |
| bid_valid | input | 1 | Received BSSID valid |
| bid_ready | output | 1 | Filter can take a BSSID |
| bid_data | input | 48 | Received BSSID |
| res_valid | output | 1 | Verdict valid |
| res_ready | input | 1 | Consumer takes the verdict |
| res_accept | output | 1 | 1 = accept, 0 = reject |

## Verification
The bench builds the filter with its default 48-bit address and 32-bit word. The upper word is therefore 16 bits wide and only the low part of `cfg_wdata` reaches it. This exposes any slip in how the words are split and how the byte lanes are compared. The directed part walks the worked four-bit case in the low bits and the write-priority corners. The random part mixes stalls on the result stream with BSSIDs one bit flip away from the MAC, so both accept and reject verdicts occur under back-pressure.

// File: rtl/bssid_filter_pkg.sv
package bssid_filter_pkg;
  localparam int unsigned DEF_ADDR_W = 48;
  localparam int unsigned DEF_WORD_W = 32;
  localparam int unsigned LANE_W     = 8;

  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,
    ACC_INIT = 2'd1,
    ACC_FOLD = 2'd2
  } acc_op_e;
endpackage

// File: rtl/bf_word_reg.sv
module bf_word_reg #(
  parameter int unsigned ADDR_W   = bssid_filter_pkg::DEF_ADDR_W,
  parameter int unsigned WORD_W   = bssid_filter_pkg::DEF_WORD_W,
  parameter bit          RST_ONES = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] q
);
  // Upper word width; ADDR_W must not exceed 2*WORD_W.
  localparam int unsigned HI_W = ADDR_W - WORD_W;
  localparam logic [WORD_W-1:0] LO_RST = {WORD_W{RST_ONES}};
  localparam logic [HI_W-1:0]   HI_RST = {HI_W{RST_ONES}};

  logic [WORD_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       lo_q <= LO_RST;
    else if (load_en) lo_q <= load_val[WORD_W-1:0];
    else if (lo_we)   lo_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       hi_q <= HI_RST;
    else if (load_en) hi_q <= load_val[ADDR_W-1:WORD_W];
    else if (hi_we)   hi_q <= wdata[HI_W-1:0];
  end

  assign q = {hi_q, lo_q};
endmodule

// File: rtl/bf_mask_accum.sv
module bf_mask_accum #(
  parameter int unsigned ADDR_W = bssid_filter_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              add,
  input  logic [ADDR_W-1:0] own_mac,
  input  logic [ADDR_W-1:0] bssid,
  output logic [ADDR_W-1:0] acc
);
  import bssid_filter_pkg::*;

  acc_op_e           op;
  logic [ADDR_W-1:0] common_bits;

  always_comb begin
    if (init)     op = ACC_INIT;
    else if (add) op = ACC_FOLD;
    else          op = ACC_HOLD;
  end

  // Bits on which this BSSID agrees with the own MAC.
  assign common_bits = ~(own_mac ^ bssid);

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '1;
    else begin
      unique case (op)
        ACC_INIT: acc <= '1;
        ACC_FOLD: acc <= acc & common_bits;
        default:  acc <= acc;
      endcase
    end
  end
endmodule

// File: rtl/bf_accept_stage.sv
module bf_accept_stage #(
  parameter int unsigned ADDR_W = bssid_filter_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_mac,
  input  logic [ADDR_W-1:0] mask,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_bssid,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_accept
);
  localparam int unsigned LW     = bssid_filter_pkg::LANE_W;
  localparam int unsigned NLANES = (ADDR_W + LW - 1) / LW;

  logic [NLANES-1:0] lane_ok;
  logic [ADDR_W-1:0] diff;
  logic              take;

  assign diff = (in_bssid ^ own_mac) & mask;

  // Each byte lane reports whether its masked bits agree.
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int unsigned LO = g * LW;
    localparam int unsigned HI = ((g + 1) * LW > ADDR_W) ? ADDR_W - 1 : (g + 1) * LW - 1;
    assign lane_ok[g] = ~|diff[HI:LO];
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_accept <= 1'b0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_accept <= &lane_ok;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/bssid_filter.sv
module bssid_filter #(
  parameter int unsigned ADDR_W = bssid_filter_pkg::DEF_ADDR_W,
  parameter int unsigned WORD_W = bssid_filter_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              mac_lo_we,
  input  logic              mac_hi_we,
  input  logic              mask_lo_we,
  input  logic              mask_hi_we,
  input  logic              acc_init,
  input  logic              acc_add,
  input  logic [ADDR_W-1:0] acc_bssid,
  input  logic              acc_load,
  output logic [ADDR_W-1:0] acc_mask,
  input  logic              bid_valid,
  output logic              bid_ready,
  input  logic [ADDR_W-1:0] bid_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_accept
);
  logic [ADDR_W-1:0] mac_q;
  logic [ADDR_W-1:0] mask_q;
  logic [ADDR_W-1:0] acc_q;

  bf_word_reg #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .RST_ONES(1'b0)) u_mac (
    .clk(clk), .rst_n(rst_n), .lo_we(mac_lo_we), .hi_we(mac_hi_we),
    .wdata(cfg_wdata), .load_en(1'b0), .load_val('0), .q(mac_q)
  );

  bf_word_reg #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .RST_ONES(1'b1)) u_mask (
    .clk(clk), .rst_n(rst_n), .lo_we(mask_lo_we), .hi_we(mask_hi_we),
    .wdata(cfg_wdata), .load_en(acc_load), .load_val(acc_q), .q(mask_q)
  );

  bf_mask_accum #(.ADDR_W(ADDR_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .init(acc_init), .add(acc_add),
    .own_mac(mac_q), .bssid(acc_bssid), .acc(acc_q)
  );

  bf_accept_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .own_mac(mac_q), .mask(mask_q),
    .in_valid(bid_valid), .in_ready(bid_ready), .in_bssid(bid_data),
    .out_valid(res_valid), .out_ready(res_ready), .out_accept(res_accept)
  );

  assign acc_mask = acc_q;
endmodule

// File: rtl/bssid_filter_checker.sv
module bssid_filter_checker #(
  parameter int unsigned ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_init,
  input logic              acc_add,
  input logic [ADDR_W-1:0] acc_mask,
  input logic              bid_valid,
  input logic              bid_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_accept
);
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_accept));

  p_stall_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !bid_ready);

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bid_valid && bid_ready |=> res_valid);

  p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bid_valid && bid_ready) && res_ready |=> !res_valid);

  p_init_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_init |=> &acc_mask);

  p_fold_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_add && !acc_init |=> (acc_mask & ~$past(acc_mask)) == '0);
endmodule

bind bssid_filter bssid_filter_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .acc_init(acc_init), .acc_add(acc_add),
  .acc_mask(acc_mask), .bid_valid(bid_valid), .bid_ready(bid_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_accept(res_accept)
);

// File: tb/bssid_filter_tb.sv
module bssid_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 48;
  localparam int WW = 32;
  localparam logic [AW-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [WW-1:0] cfg_wdata = '0;
  logic mac_lo_we = 0, mac_hi_we = 0, mask_lo_we = 0, mask_hi_we = 0;
  logic acc_init = 0, acc_add = 0, acc_load = 0;
  logic [AW-1:0] acc_bssid = '0;
  logic [AW-1:0] acc_mask;
  logic bid_valid = 0, bid_ready;
  logic [AW-1:0] bid_data = '0;
  logic res_valid, res_accept;
  logic res_ready = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bssid_filter #(.ADDR_W(AW), .WORD_W(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wdata(cfg_wdata),
    .mac_lo_we(mac_lo_we), .mac_hi_we(mac_hi_we),
    .mask_lo_we(mask_lo_we), .mask_hi_we(mask_hi_we),
    .acc_init(acc_init), .acc_add(acc_add), .acc_bssid(acc_bssid),
    .acc_load(acc_load), .acc_mask(acc_mask),
    .bid_valid(bid_valid), .bid_ready(bid_ready), .bid_data(bid_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_accept(res_accept)
  );

  // Reference model state, updated at each rising edge.
  logic [AW-1:0] m_mac, m_mask, m_acc;
  bit m_ov, m_oa;

  always @(posedge clk) begin
    logic [AW-1:0] nmac, nmask, nacc;
    bit nov, noa;
    if (!rst_n) begin
      m_mac = '0; m_mask = ONES; m_acc = ONES; m_ov = 0; m_oa = 0;
    end else begin
      nmac = m_mac; nmask = m_mask; nacc = m_acc; nov = m_ov; noa = m_oa;
      if (bid_valid && (!m_ov || res_ready)) begin
        nov = 1;
        noa = ((bid_data & m_mask) == (m_mac & m_mask));
      end else if (res_ready) nov = 0;
      if (acc_init) nacc = ONES;
      else if (acc_add) nacc = m_acc & ~(m_mac ^ acc_bssid);
      if (mac_lo_we) nmac[31:0] = cfg_wdata;
      if (mac_hi_we) nmac[47:32] = cfg_wdata[15:0];
      if (acc_load) nmask = m_acc;
      else begin
        if (mask_lo_we) nmask[31:0] = cfg_wdata;
        if (mask_hi_we) nmask[47:32] = cfg_wdata[15:0];
      end
      m_mac = nmac; m_mask = nmask; m_acc = nacc; m_ov = nov; m_oa = noa;
    end
  end

  task automatic cmp(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      cmp("R7 bid_ready", {47'd0, bid_ready}, {47'd0, (!m_ov || res_ready)});
      cmp("R6 res_valid", {47'd0, res_valid}, {47'd0, m_ov});
      cmp("R4 acc_mask", acc_mask, m_acc);
      if (m_ov) cmp("R2 res_accept", {47'd0, res_accept}, {47'd0, m_oa});
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    mac_lo_we = 0; mac_hi_we = 0; mask_lo_we = 0; mask_hi_we = 0;
    acc_init = 0; acc_add = 0; acc_load = 0; bid_valid = 0;
  endtask

  task automatic wr_mac(input logic [AW-1:0] v);
    cfg_wdata = v[31:0]; mac_lo_we = 1; tick(); idle();
    cfg_wdata = {16'd0, v[47:32]}; mac_hi_we = 1; tick(); idle();
  endtask

  task automatic fold(input logic [AW-1:0] b);
    acc_bssid = b; acc_add = 1; tick(); idle();
  endtask

  task automatic send_chk(input string req, input logic [AW-1:0] b, input bit exp);
    bid_data = b; bid_valid = 1; tick(); idle();
    cmp(req, {47'd0, res_valid}, 48'd1);
    cmp(req, {47'd0, res_accept}, {47'd0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; #1;
    // R1: reset state
    cmp("R1 res_valid", {47'd0, res_valid}, 48'd0);
    cmp("R1 bid_ready", {47'd0, bid_ready}, 48'd1);
    cmp("R1 acc_mask", acc_mask, ONES);
    tick();
    // R1/R8: all-ones mask, MAC zero
    send_chk("R8 exact", 48'd0, 1);
    send_chk("R8 one-bit off", 48'd1, 0);
    // R9 worked case
    wr_mac(48'd1);
    acc_init = 1; tick(); idle();
    fold(48'd4);
    fold(48'd9);
    cmp("R9 mask", acc_mask, 48'hFFFF_FFFF_FFF2);
    acc_load = 1; tick(); idle();
    send_chk("R9 reject 6", 48'd6, 0);
    send_chk("R9 accept 1", 48'd1, 1);
    send_chk("R9 accept 4", 48'd4, 1);
    send_chk("R9 accept 9", 48'd9, 1);
    send_chk("R9 false accept 13", 48'd13, 1);
    // R4: init wins over add
    acc_init = 1; acc_add = 1; acc_bssid = 48'hFFFF; tick(); idle();
    cmp("R4 init priority", acc_mask, ONES);
    // R5: load beats mask low write
    cfg_wdata = '0; mask_lo_we = 1; acc_load = 1; tick(); idle();
    send_chk("R5 load priority", 48'd0, 0);
    // R3: upper word write
    wr_mac(48'hABCD_0000_0001);
    send_chk("R3 hi match", 48'hABCD_0000_0001, 1);
    send_chk("R3 hi differs", 48'h0000_0000_0001, 0);
    cfg_wdata = 32'h0000_FFFF; mask_hi_we = 1; tick(); idle();
    cfg_wdata = 32'hFFFF_FFFF; mask_lo_we = 1; tick(); idle();
    cfg_wdata = 32'h0000_0000; mask_hi_we = 1; tick(); idle();
    send_chk("R3 hi masked off", 48'h1234_0000_0001, 1);
    // R7: back-pressure
    res_ready = 0;
    bid_data = 48'hABCD_0000_0001; bid_valid = 1; tick();
    cmp("R7 blocked", {47'd0, bid_ready}, 48'd0);
    bid_data = 48'd5; tick(); tick();
    cmp("R7 held valid", {47'd0, res_valid}, 48'd1);
    cmp("R7 held accept", {47'd0, res_accept}, 48'd1);
    idle(); res_ready = 1; tick();
    cmp("R7 drained", {47'd0, res_valid}, 48'd0);
    // R6: back-to-back throughput
    bid_valid = 1; bid_data = 48'd1; tick();
    bid_data = 48'd2; tick();
    cmp("R6 second verdict", {47'd0, res_accept}, 48'd0);
    idle(); tick();
    // Random mixed traffic, checked every clock by the model
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom;
      idle();
      res_ready = (r[3:0] != 0);
      bid_valid = r[4];
      bid_data = m_mac ^ (r[5] ? (48'd1 << r[11:6] % AW) : 48'd0);
      if (r[15:12] == 0) begin acc_add = 1; acc_bssid = m_mac ^ (48'd1 << r[21:16] % AW); end
      if (r[15:12] == 1) acc_init = 1;
      if (r[15:12] == 2) acc_load = 1;
      if (r[15:12] == 3) begin cfg_wdata = $urandom; mask_lo_we = 1; end
      if (r[15:12] == 4) begin cfg_wdata = $urandom; mac_hi_we = r[22]; mac_lo_we = !r[22]; end
      tick();
    end
    idle(); res_ready = 1; tick(); tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule